// File: doc/BRIEF.md
# Streaming SPI Register Slave

This block gives an off-chip host read and write access to a small bank of byte-wide configuration registers over a four-wire SPI link in mode 0. The link pins (active-low select, serial clock, data in, data out) are brought into the block's own clock domain through short synchronizer chains. All protocol logic then runs on the system clock, so the system clock must be several times faster than the serial clock.

Every transaction opens with a command byte that picks a streaming read or a streaming write. A start address byte comes next, and then any number of data bytes. The register pointer advances by one after each data byte until select goes high. Four low addresses hold fixed identification bytes. The writable registers drive plain output ports: a general configuration bank, a reset request, a 32-bit trim word, two 3-bit source selects and a 5-bit divider.

Top module: `spi_regbank`

## Requirements
- R1: Data is transferred MSB first in SPI mode 0: the slave samples `spi_mosi` on rising `spi_sclk`, and `spi_miso` changes only after a falling `spi_sclk` edge, the completion of a byte, or deselection.
- R2: The first byte after select falls is a command: 0x40 starts a streaming read and 0x80 a streaming write. Any other value makes the rest of the transaction a no-op that writes nothing and returns 0x00 bytes.
- R3: The second byte is the start address. In a read, the first data byte returned is the register at that address.
- R4: After each data byte the address steps up by one, wrapping from 0xff to 0x00, and this continues for as long as select stays low.
- R5: After reset, addresses 0x00..0x12 read 00 04 56 11 00 00 00 00 02 01 00 00 00 ff ef ff 03 12 04.
- R6: Addresses 0x00..0x03 are read-only identification bytes, and writes to them are ignored.
- R7: Bit 0 of register 0x0b drives `ext_reset_req`. Writing 0x01 asserts it and writing 0x00 releases it.
- R8: Registers 0x0d..0x10 form `trim_word`, with 0x0d as the most significant byte. Register 0x11 bits [2:0] drive `src_sel_a` and bits [5:3] drive `src_sel_b`. Register 0x12 bits [4:0] drive `div_value`. Bits these fields do not use read back as 0. The output ports change only when a write byte completes.
- R9: Addresses above 0x12 read as 0x00, and writes to them are ignored.
- R10: Raising select ends the transaction. The next select window starts again with a command byte, and a partial byte left at deselection writes nothing.
- R11: `spi_miso` is 0 while select is high.
- R12: `aux_cfg` carries registers 0x04..0x0a in bytes 0..6 and register 0x0c in byte 7. Register 0x0b holds only its bit 0; its other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Active-low select from the host |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| ext_reset_req | output | 1 | Reset request, bit 0 of register 0x0b |
| aux_cfg | output | 64 | General configuration bytes (registers 0x04..0x0a, 0x0c) |
| trim_word | output | 32 | Trim value from registers 0x0d..0x10 |
| src_sel_a | output | 3 | Source select from register 0x11 [2:0] |
| src_sel_b | output | 3 | Source select from register 0x11 [5:3] |
| div_value | output | 5 | Divider from register 0x12 [4:0] |

## Verification
The checker holds four rules on every cycle. `spi_miso` stays low and the bit counter stays cleared while deselected. The serial output changes only on a falling clock, a byte boundary or deselection. The reset request and the trim, select and divider ports move only in the cycle after a completed write byte. The values themselves can only be shown by the bench's scenarios: reset contents, pointer advance and wrap, ignored writes to identification and unused addresses, masked field widths, invalid commands and discarded partial bytes. In those scenarios a reference model is compared against the output ports on every idle clock.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter logic [31:0] ID_WORD = 32'h1156_0400,
  parameter int          SYNC_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_csn,
  input  logic        spi_sclk,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        ext_reset_req,
  output logic [63:0] aux_cfg,
  output logic [31:0] trim_word,
  output logic [2:0]  src_sel_a,
  output logic [2:0]  src_sel_b,
  output logic [4:0]  div_value
);
  localparam int         FIRST_RW = 4;
  localparam int         LAST_REG = 18;
  localparam int         RST_REG  = 11;
  localparam logic [7:0] CMD_RD   = 8'h40;
  localparam logic [7:0] CMD_WR   = 8'h80;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} phase_t;

  function automatic logic [7:0] rst_val(int i);
    case (i)
      8:  return 8'h02;
      9:  return 8'h01;
      13: return 8'hff;
      14: return 8'hef;
      15: return 8'hff;
      16: return 8'h03;
      17: return 8'h12;
      18: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_mask(int i);
    case (i)
      RST_REG: return 8'h01;
      17:      return 8'h3f;
      18:      return 8'h1f;
      default: return 8'hff;
    endcase
  endfunction

  logic [SYNC_W-1:0] csn_q, sclk_q, mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      csn_q  <= '1;
      sclk_q <= '0;
      mosi_q <= '0;
    end else begin
      csn_q  <= {csn_q[SYNC_W-2:0], spi_csn};
      sclk_q <= {sclk_q[SYNC_W-2:0], spi_sclk};
      mosi_q <= {mosi_q[SYNC_W-2:0], spi_mosi};
    end

  logic cs_act, sclk_rise, sclk_fall, mosi_bit;
  assign cs_act    = ~csn_q[SYNC_W-2];
  assign sclk_rise = sclk_q[SYNC_W-2] & ~sclk_q[SYNC_W-1];
  assign sclk_fall = ~sclk_q[SYNC_W-2] & sclk_q[SYNC_W-1];
  assign mosi_bit  = mosi_q[SYNC_W-2];

  phase_t      phase;
  logic        rd_mode, wr_mode;
  logic [2:0]  bit_cnt;
  logic [6:0]  sh_in;
  logic [7:0]  sh_out, addr, rx_byte, rd_addr, rd_data;
  logic        byte_done, wr_stb;
  logic [7:0]  regs [FIRST_RW:LAST_REG];

  assign rx_byte   = {sh_in, mosi_bit};
  assign byte_done = cs_act & sclk_rise & (bit_cnt == 3'd7);
  assign wr_stb    = byte_done & (phase == PH_DATA) & wr_mode;
  assign rd_addr   = (phase == PH_ADDR) ? rx_byte : addr + 8'd1;

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < FIRST_RW; i++)
      if (rd_addr == 8'(i)) rd_data = ID_WORD[8*i +: 8];
    for (int i = FIRST_RW; i <= LAST_REG; i++)
      if (rd_addr == 8'(i)) rd_data = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_CMD;
      rd_mode <= 1'b0;
      wr_mode <= 1'b0;
      bit_cnt <= '0;
      sh_in   <= '0;
      sh_out  <= '0;
      addr    <= '0;
    end else if (!cs_act) begin
      phase   <= PH_CMD;
      rd_mode <= 1'b0;
      wr_mode <= 1'b0;
      bit_cnt <= '0;
      sh_out  <= '0;
    end else if (sclk_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      sh_in   <= rx_byte[6:0];
      if (bit_cnt == 3'd7) begin
        case (phase)
          PH_CMD: begin
            rd_mode <= (rx_byte == CMD_RD);
            wr_mode <= (rx_byte == CMD_WR);
            phase   <= PH_ADDR;
          end
          PH_ADDR: begin
            addr  <= rx_byte;
            phase <= PH_DATA;
            if (rd_mode) sh_out <= rd_data;
          end
          default: begin
            addr <= addr + 8'd1;
            if (rd_mode) sh_out <= rd_data;
          end
        endcase
      end
    end else if (sclk_fall && bit_cnt != 3'd0) begin
      sh_out <= {sh_out[6:0], 1'b0};
    end

  for (genvar g = FIRST_RW; g <= LAST_REG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        regs[g] <= rst_val(g);
      else if (wr_stb && addr == 8'(g))
        regs[g] <= rx_byte & wr_mask(g);
  end

  for (genvar g = 0; g < 7; g++) begin : g_aux
    assign aux_cfg[8*g +: 8] = regs[FIRST_RW + g];
  end
  assign aux_cfg[63:56] = regs[12];

  assign spi_miso      = sh_out[7];
  assign ext_reset_req = regs[RST_REG][0];
  assign trim_word     = {regs[13], regs[14], regs[15], regs[16]};
  assign src_sel_a     = regs[17][2:0];
  assign src_sel_b     = regs[17][5:3];
  assign div_value     = regs[18][4:0];
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_act,
  input logic        sclk_fall,
  input logic        byte_done,
  input logic        wr_stb,
  input logic [7:0]  addr,
  input logic [2:0]  bit_cnt,
  input logic        spi_miso,
  input logic        ext_reset_req,
  input logic [31:0] trim_word,
  input logic [2:0]  src_sel_a,
  input logic [2:0]  src_sel_b,
  input logic [4:0]  div_value
);
  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);

  // R10
  bitcnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bit_cnt == 3'd0);

  // R1
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso != $past(spi_miso)) |-> $past(sclk_fall || byte_done || !cs_act));

  // R7
  rstreq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_reset_req != $past(ext_reset_req)) |-> $past(wr_stb && addr == 8'h0b));

  // R8
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> ($stable(trim_word) && $stable(src_sel_a) &&
                        $stable(src_sel_b) && $stable(div_value)));
endmodule

bind spi_regbank spi_regbank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .byte_done(byte_done), .wr_stb(wr_stb), .addr(addr), .bit_cnt(bit_cnt),
  .spi_miso(spi_miso), .ext_reset_req(ext_reset_req), .trim_word(trim_word),
  .src_sel_a(src_sel_a), .src_sel_b(src_sel_b), .div_value(div_value)
);

// File: tb/spi_regbank_tb_top.sv
`timescale 1ns/1ps
module spi_regbank_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, ext_reset_req;
  logic [63:0] aux_cfg;
  logic [31:0] trim_word;
  logic [2:0]  src_sel_a, src_sel_b;
  logic [4:0]  div_value;

  always #4 clk = ~clk;

  spi_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .ext_reset_req(ext_reset_req),
    .aux_cfg(aux_cfg), .trim_word(trim_word), .src_sel_a(src_sel_a),
    .src_sel_b(src_sel_b), .div_value(div_value)
  );

  int checks = 0, errors = 0;
  bit cmp_en = 0, finished = 0;
  logic [7:0] mdl [0:255];

  function automatic logic [7:0] mask_of(int a);
    if (a == 11) return 8'h01;
    if (a == 17) return 8'h3f;
    if (a == 18) return 8'h1f;
    return 8'hff;
  endfunction

  function automatic void mdl_write(int a, logic [7:0] d);
    if (a >= 4 && a <= 18) mdl[a] = d & mask_of(a);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of the output ports against the model (R7 R8 R11 R12)
  always @(negedge clk) if (cmp_en) begin
    chk("R12 aux_cfg", aux_cfg, {mdl[12], mdl[10], mdl[9], mdl[8], mdl[7], mdl[6], mdl[5], mdl[4]});
    chk("R8 trim/sel/div", {trim_word, src_sel_b, src_sel_a, div_value},
        {mdl[13], mdl[14], mdl[15], mdl[16], mdl[17][5:3], mdl[17][2:0], mdl[18][4:0]});
    chk("R7 ext_reset_req", ext_reset_req, mdl[11][0]);
    chk("R11 miso idle", spi_miso, 1'b0);
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    cmp_en = 0;
    spi_csn = 0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    spi_sclk = 0;
    wait_clk(HALF);
    spi_csn = 1;
    wait_clk(8);
    cmp_en = 1;
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_sclk = 0;
      spi_mosi = tx[i];
      wait_clk(HALF);
      rx[i] = spi_miso;
      spi_sclk = 1;
      wait_clk(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic read_stream(string req, int start, int n);
    logic [7:0] rx;
    cs_begin();
    xfer(8'h40, rx);
    xfer(8'(start), rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx);
      chk(req, rx, mdl[(start + k) & 255]);
    end
    cs_end();
  endtask

  task automatic write_stream(int start, logic [7:0] d[$]);
    logic [7:0] rx;
    cs_begin();
    xfer(8'h80, rx);
    xfer(8'(start), rx);
    foreach (d[k]) begin
      xfer(d[k], rx);
      mdl_write((start + k) & 255, d[k]);
    end
    cs_end();
  endtask

  initial begin
    logic [7:0] rx;
    logic [7:0] rst_list [0:18] = '{8'h00, 8'h04, 8'h56, 8'h11, 8'h00, 8'h00, 8'h00,
      8'h00, 8'h02, 8'h01, 8'h00, 8'h00, 8'h00, 8'hff, 8'hef, 8'hff, 8'h03, 8'h12, 8'h04};
    for (int a = 0; a < 256; a++) mdl[a] = (a <= 18) ? rst_list[a] : 8'h00;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);

    // R5 reset state at the ports
    chk("R5 reset trim", trim_word, 32'hffef_ff03);
    chk("R5 reset sel/div", {src_sel_b, src_sel_a, div_value}, {3'd2, 3'd2, 5'd4});
    chk("R5 reset aux", aux_cfg, 64'h0000_0102_0000_0000);
    chk("R5 reset ext_reset_req", ext_reset_req, 1'b0);
    cmp_en = 1;

    // R1 R3 R4 R5: full streaming read from address 0
    read_stream("R5 reset readback", 0, 19);
    // R3 start in the middle
    read_stream("R3 start address", 13, 3);

    // R8 trim word write, MSB first at 0x0d
    write_stream(13, '{8'h12, 8'h34, 8'h56, 8'h78});
    chk("R8 trim value", trim_word, 32'h1234_5678);
    // R8 packed fields and masked bits
    write_stream(17, '{8'hff, 8'hff});
    chk("R8 fields", {src_sel_b, src_sel_a, div_value}, {3'd7, 3'd7, 5'd31});
    read_stream("R8 masked readback", 17, 2);

    // R7 reset request
    write_stream(11, '{8'h01});
    chk("R7 assert", ext_reset_req, 1'b1);
    write_stream(11, '{8'h00});
    chk("R7 release", ext_reset_req, 1'b0);
    // R12 register 0x0b keeps only bit 0, general bytes full width
    write_stream(4, '{8'ha1, 8'hb2, 8'hc3, 8'hd4, 8'he5, 8'hf6, 8'h07, 8'hfe, 8'h99});
    chk("R12 aux after write", aux_cfg, 64'h9907_f6e5_d4c3_b2a1);
    read_stream("R12 readback", 4, 9);

    // R6 identification bytes ignore writes
    write_stream(0, '{8'haa, 8'hbb, 8'hcc, 8'hdd});
    read_stream("R6 id unchanged", 0, 4);

    // R9 unimplemented addresses
    write_stream(19, '{8'h5a, 8'h5a});
    read_stream("R9 unimplemented reads zero", 19, 3);

    // R4 wrap from 0xff to 0x00
    read_stream("R4 wrap", 254, 4);

    // R2 invalid commands: no write, zero data
    cs_begin();
    xfer(8'h00, rx);
    xfer(8'h0d, rx);
    xfer(8'h55, rx);
    chk("R2 invalid cmd data", rx, 8'h00);
    cs_end();
    cs_begin();
    xfer(8'hc0, rx);
    xfer(8'h12, rx);
    xfer(8'h01, rx);
    chk("R2 invalid cmd data", rx, 8'h00);
    cs_end();
    chk("R2 trim untouched", trim_word, 32'h1234_5678);

    // R10 partial byte discarded, next window restarts with a command
    cs_begin();
    xfer(8'h80, rx);
    xfer(8'h12, rx);
    xfer_bits(8'h00, 5, rx);
    cs_end();
    chk("R10 partial discarded", div_value, 5'd31);
    read_stream("R10 fresh command", 18, 1);

    cmp_en = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule